// File: doc/BRIEF.md
# Round-Robin Interleaved Four-Operand Adder Array

This block reaches a throughput of one operand set per clock with compute units that each need several clocks per job. It holds `NUM_UNITS` copies of a slow unit that adds four operands. A dispatch counter hands each incoming operand set to the next unit in a fixed rotation. A second counter, offset from the first by the unit latency, selects which unit's finished result goes to the registered output. Results therefore leave in the order their inputs arrived, and each one takes exactly `UNIT_LAT` clocks from input to output, the same as a single unit.

The input is a valid flag with four operands, and the output is a valid flag with a sum. The block has no ready signal and no back-pressure. An operand set is taken on every rising clock edge outside reset, and the consumer must take every result in the cycle it appears. A cycle with the valid flag low still uses up a rotation slot, and it comes out as a cycle with the output valid flag low. `UNIT_LAT` must lie between 2 and `NUM_UNITS`, so that each unit has finished before it is chosen again.

Top module: `iarr_interleave_top`

## Requirements
- R1: While `rst_n` is low, and in the `UNIT_LAT` cycles after it is released, `out_valid` is 0. The first operand set accepted after reset is dispatched to unit 0.
- R2: `out_sum` equals `in_a + in_b + in_c + in_d`, computed at `DATA_W + 2` bits, so it never wraps. All-ones operands included.
- R3: An operand set accepted at rising edge k appears on `out_valid`/`out_sum` right after rising edge k + `UNIT_LAT`, and not in any other cycle.
- R4: Results leave in the same order as their operand sets were accepted.
- R5: Operand sets accepted on every consecutive clock each produce their own result, on consecutive clocks.
- R6: A cycle with `in_valid` low advances the rotation and yields a cycle with `out_valid` low `UNIT_LAT` clocks later. Once no valid input has arrived for more than `UNIT_LAT` edges, `out_valid` stays 0.
- R7: Dispatch visits units 0, 1, ..., `NUM_UNITS`-1 and then wraps to 0, moving one step on every clock. Exactly one unit is loaded per clock.
- R8: A unit is never loaded while it still has a job in progress.
- R9: Asserting `rst_n` low in the middle of a stream discards every job in flight. No result from before the reset appears afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand set on this edge is valid |
| in_a | input | DATA_W | Operand 0 |
| in_b | input | DATA_W | Operand 1 |
| in_c | input | DATA_W | Operand 2 |
| in_d | input | DATA_W | Operand 3 |
| out_valid | output | 1 | `out_sum` carries a result |
| out_sum | output | DATA_W+2 | Sum of the four operands |

## Verification
The assertions assume that the input is sampled on every edge without exception, because the block has no stall. They also assume that `UNIT_LAT` does not exceed `NUM_UNITS`, since the no-reload-while-busy property depends on it. The stimulus drives a fresh operand set, or a deliberate invalid slot, every clock. It never pauses the input, and it keeps the default configuration, in which the unit latency equals the number of units. Runs of all-valid inputs, sparse inputs, inputs spaced one rotation apart, all-ones operands and a reset in the middle of a stream cover the ordering and drain properties.

// File: rtl/iarr_pkg.sv
package iarr_pkg;
  localparam int NUM_OPS = 4;

  function automatic int sum_width(input int data_w);
    return data_w + $clog2(NUM_OPS);
  endfunction

  function automatic int idx_width(input int count);
    return (count > 1) ? $clog2(count) : 1;
  endfunction
endpackage

// File: rtl/iarr_rr_counter.sv
module iarr_rr_counter #(
  parameter int COUNT = 4,
  parameter int START = 0,
  localparam int IW = iarr_pkg::idx_width(COUNT)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [IW-1:0] idx
);
  localparam logic [IW-1:0] LAST = IW'(COUNT - 1);
  localparam logic [IW-1:0] INIT = IW'(START);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx <= INIT;
    else if (idx == LAST) idx <= '0;
    else idx <= idx + 1'b1;
  end
endmodule

// File: rtl/iarr_sum4_unit.sv
module iarr_sum4_unit #(
  parameter int DATA_W = 16,
  parameter int UNIT_LAT = 4,
  localparam int SW = iarr_pkg::sum_width(DATA_W),
  localparam int OPS = iarr_pkg::NUM_OPS,
  localparam int CW = $clog2(UNIT_LAT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              load_valid,
  input  logic [OPS*DATA_W-1:0] load_ops,
  output logic              res_valid,
  output logic [SW-1:0]     res_sum,
  output logic              busy
);
  localparam logic [CW-1:0] FINAL = CW'(UNIT_LAT - 1);

  logic [OPS*DATA_W-1:0] ops_q;
  logic                  tag_q;
  logic [CW-1:0]         step_q;
  logic [SW-1:0]         sum_c;

  // Slow path: allowed UNIT_LAT-1 clocks from operand capture to result.
  always_comb begin
    sum_c = '0;
    for (int i = 0; i < OPS; i++)
      sum_c = sum_c + SW'(ops_q[i*DATA_W +: DATA_W]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ops_q     <= '0;
      tag_q     <= 1'b0;
      step_q    <= '0;
      res_valid <= 1'b0;
      res_sum   <= '0;
    end else if (load) begin
      ops_q  <= load_ops;
      tag_q  <= load_valid;
      step_q <= CW'(1);
    end else if (step_q != '0) begin
      if (step_q == FINAL) begin
        res_sum   <= sum_c;
        res_valid <= tag_q;
        step_q    <= '0;
      end else begin
        step_q <= step_q + 1'b1;
      end
    end
  end

  assign busy = (step_q != '0);
endmodule

// File: rtl/iarr_result_mux.sv
module iarr_result_mux #(
  parameter int COUNT = 4,
  parameter int SW = 18,
  localparam int IW = iarr_pkg::idx_width(COUNT)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [IW-1:0]       sel,
  input  logic [COUNT-1:0]    vld_vec,
  input  logic [COUNT*SW-1:0] sum_vec,
  output logic                out_valid,
  output logic [SW-1:0]       out_sum
);
  logic          pick_v;
  logic [SW-1:0] pick_s;

  always_comb begin
    pick_v = 1'b0;
    pick_s = '0;
    for (int i = 0; i < COUNT; i++) begin
      if (sel == IW'(i)) begin
        pick_v = vld_vec[i];
        pick_s = sum_vec[i*SW +: SW];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sum   <= '0;
    end else begin
      out_valid <= pick_v;
      out_sum   <= pick_s;
    end
  end
endmodule

// File: rtl/iarr_interleave_top.sv
module iarr_interleave_top #(
  parameter int NUM_UNITS = 4,
  parameter int UNIT_LAT = 4,
  parameter int DATA_W = 16,
  localparam int SW = iarr_pkg::sum_width(DATA_W),
  localparam int IW = iarr_pkg::idx_width(NUM_UNITS),
  localparam int OPS = iarr_pkg::NUM_OPS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  input  logic [DATA_W-1:0] in_c,
  input  logic [DATA_W-1:0] in_d,
  output logic              out_valid,
  output logic [SW-1:0]     out_sum
);
  // The output pointer trails dispatch by UNIT_LAT slots, modulo NUM_UNITS.
  localparam int OUT_START = (NUM_UNITS - (UNIT_LAT % NUM_UNITS)) % NUM_UNITS;

  logic [IW-1:0]            isel;
  logic [IW-1:0]            osel;
  logic [NUM_UNITS-1:0]     load_vec;
  logic [NUM_UNITS-1:0]     busy_vec;
  logic [NUM_UNITS-1:0]     rvld_vec;
  logic [NUM_UNITS*SW-1:0]  rsum_vec;
  logic [OPS*DATA_W-1:0]    ops_flat;

  assign ops_flat = {in_d, in_c, in_b, in_a};

  iarr_rr_counter #(.COUNT(NUM_UNITS), .START(0)) u_dispatch_ptr (
    .clk(clk), .rst_n(rst_n), .idx(isel)
  );

  iarr_rr_counter #(.COUNT(NUM_UNITS), .START(OUT_START)) u_collect_ptr (
    .clk(clk), .rst_n(rst_n), .idx(osel)
  );

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    assign load_vec[u] = (isel == IW'(u));

    iarr_sum4_unit #(.DATA_W(DATA_W), .UNIT_LAT(UNIT_LAT)) u_unit (
      .clk(clk),
      .rst_n(rst_n),
      .load(load_vec[u]),
      .load_valid(in_valid),
      .load_ops(ops_flat),
      .res_valid(rvld_vec[u]),
      .res_sum(rsum_vec[u*SW +: SW]),
      .busy(busy_vec[u])
    );
  end

  iarr_result_mux #(.COUNT(NUM_UNITS), .SW(SW)) u_out_mux (
    .clk(clk),
    .rst_n(rst_n),
    .sel(osel),
    .vld_vec(rvld_vec),
    .sum_vec(rsum_vec),
    .out_valid(out_valid),
    .out_sum(out_sum)
  );
endmodule

// File: rtl/iarr_checker.sv
module iarr_checker #(
  parameter int NUM_UNITS = 4,
  parameter int UNIT_LAT = 4,
  localparam int IW = iarr_pkg::idx_width(NUM_UNITS),
  localparam int QW = $clog2(UNIT_LAT + 2)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 out_valid,
  input logic [IW-1:0]        isel,
  input logic [NUM_UNITS-1:0] load_vec,
  input logic [NUM_UNITS-1:0] busy_vec
);
  localparam logic [QW-1:0] QUIET_MAX = QW'(UNIT_LAT + 1);

  logic [QW-1:0] quiet_q;

  // Counts edges since the last valid input, saturating past the latency.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) quiet_q <= QUIET_MAX;
    else if (in_valid) quiet_q <= '0;
    else if (quiet_q != QUIET_MAX) quiet_q <= quiet_q + 1'b1;
  end

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> !out_valid); // R1

  AST_ROTATE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (isel == (($past(isel) == IW'(NUM_UNITS - 1)) ? '0 : $past(isel) + 1'b1))); // R7

  AST_ONE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(load_vec)); // R7

  AST_NO_BUSY_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (load_vec & busy_vec) == '0); // R8

  AST_DRAIN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet_q == QUIET_MAX) |-> !out_valid); // R6
endmodule

bind iarr_interleave_top iarr_checker #(.NUM_UNITS(NUM_UNITS), .UNIT_LAT(UNIT_LAT)) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .in_valid(in_valid),
  .out_valid(out_valid),
  .isel(isel),
  .load_vec(load_vec),
  .busy_vec(busy_vec)
);

// File: tb/iarr_interleave_top_tb.sv
module iarr_interleave_top_tb;
  localparam int NU = 4;
  localparam int LAT = 4;
  localparam int DW = 16;
  localparam int SW = DW + 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_a = '0, in_b = '0, in_c = '0, in_d = '0;
  logic          out_valid;
  logic [SW-1:0] out_sum;

  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  string tag = "R1";

  logic [SW:0]   q[$];       // {valid, sum}
  logic          exp_v = 1'b0;
  logic [SW-1:0] exp_s = '0;

  always #4 clk = ~clk;

  iarr_interleave_top #(.NUM_UNITS(NU), .UNIT_LAT(LAT), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_a(in_a), .in_b(in_b), .in_c(in_c), .in_d(in_d),
    .out_valid(out_valid), .out_sum(out_sum)
  );

  // Reference: every accepted slot emerges LAT edges later, in order.
  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      exp_v <= 1'b0;
    end else begin
      logic [SW:0] item;
      item = {in_valid, SW'(in_a) + SW'(in_b) + SW'(in_c) + SW'(in_d)};
      q.push_back(item);
      if (q.size() > LAT) begin
        item = q.pop_front();
        exp_v <= item[SW];
        exp_s <= item[SW-1:0];
      end else begin
        exp_v <= 1'b0;
      end
    end
  end

  task automatic compare();
    checks++;
    if (out_valid !== exp_v) begin
      errors++;
      $display("FAIL %s: out_valid actual %b expected %b", tag, out_valid, exp_v);
    end else if (exp_v && out_sum !== exp_s) begin
      errors++;
      $display("FAIL %s: out_sum actual %0d expected %0d", tag, out_sum, exp_s);
    end
  endtask

  task automatic step(input bit v, input logic [DW-1:0] a, b, c, d);
    @(negedge clk);
    compare();
    in_valid = v; in_a = a; in_b = b; in_c = c; in_d = d;
  endtask

  task automatic step_rand(input bit v);
    step(v, DW'($urandom), DW'($urandom), DW'($urandom), DW'($urandom));
  endtask

  initial begin
    tag = "R1";
    repeat (3) step(1'b0, '0, '0, '0, '0);
    rst_n = 1'b1;
    for (int i = 0; i < LAT + 2; i++) step_rand(1'b1);

    tag = "R5";
    for (int i = 0; i < 100; i++) step_rand(1'b1);

    tag = "R4";
    for (int i = 0; i < 40; i++) step(1'b1, DW'(i), DW'(3 * i), '0, DW'(1));

    tag = "R2";
    for (int i = 0; i < 8; i++) step(1'b1, '1, '1, '1, '1);
    for (int i = 0; i < 4; i++) step(1'b1, '0, '0, '0, '0);

    tag = "R3";
    for (int k = 0; k < 5; k++) begin
      step_rand(1'b1);
      for (int i = 0; i < LAT + 3; i++) step_rand(1'b0);
    end

    tag = "R6";
    for (int i = 0; i < 80; i++) step_rand(($urandom % 2) == 0);
    for (int i = 0; i < LAT + 3; i++) step_rand(1'b0);

    tag = "R7/R8";
    for (int i = 0; i < 40; i++) step_rand((i % NU) == 0);
    for (int i = 0; i < 40; i++) step_rand((i % NU) == 1);

    tag = "R9";
    for (int i = 0; i < 10; i++) step_rand(1'b1);
    @(negedge clk);
    compare();
    rst_n = 1'b0;
    in_valid = 1'b0;
    repeat (2) step_rand(1'b0);
    rst_n = 1'b1;
    for (int i = 0; i < LAT + 3; i++) step_rand(1'b0);
    for (int i = 0; i < 20; i++) step_rand(1'b1);
    for (int i = 0; i < LAT + 2; i++) step_rand(1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule